// File: doc/BRIEF.md
# Precise Exception Commit Unit

This block sits at the writeback end of a five-stage in-order pipeline. Each cycle it looks at the instruction held in every stage: its virtual PC, a valid bit, an exception-pending bit, a 5-bit cause code, a load-hit flag and the register-file and memory write requests. From these it produces one precise exception. The block always chooses the oldest pending exception in program order. The cycle in which an exception was detected plays no part in that choice. In the same cycle, the block gates the write enables of the faulting instruction and of every younger instruction. Exceptions raised by those younger instructions are dropped and never reported.

One edge after acceptance, the block raises a single-cycle redirect strobe toward a constant handler vector. With that strobe it flushes the fetch, decode, execute and memory stages and loads the exception-PC and cause registers. During the strobe cycle the stage contents are already doomed, so the block ignores them.

A cache data parity error on a load that hit in the cache is handled differently. That load's register write still goes through, and the cache-error register is loaded with the load's PC alongside the exception-PC register. The handler must then rewrite the destination register before it restarts the load. Every other fault leaves no architectural trace, so the handler can re-execute it directly.

Top module: `exc_commit_unit`

## Requirements
- R1: Stage index 0 is fetch and index NSTG-1 is writeback, so a higher index is an older instruction. Among stages with both valid and pending set, the highest index is accepted. One clock after acceptance, epc_o holds that stage's PC.
- R2: A stage whose valid bit is low is never accepted, whatever its pending bit says, and its rf_we_o and mem_we_o are 0.
- R3: In the acceptance cycle, rf_we_o and mem_we_o are 0 for the accepted stage and all lower indices. Valid stages with a higher index pass their write requests through unchanged.
- R4: Pending exceptions in stages with a lower index than the accepted one are discarded. cause_o and epc_o reflect only the accepted stage, and no second redirect follows for them.
- R5: The parity-error code is 5'd16. If the accepted stage has cause 16 and ld_hit set, its rf_we_o still follows its request, its mem_we_o is 0, and one clock later cerr_o holds its PC.
- R6: For any other accepted exception, the faulting stage's rf_we_o is 0 and cerr_o keeps its previous value.
- R7: One clock after acceptance, redirect_o is high for exactly one cycle and flush_o (bits 0..NSTG-2) is all ones in that same cycle. At all other times flush_o is 0, and vector_o always equals HANDLER_VEC.
- R8: cause_o is loaded with the accepted stage's cause code on the same edge that loads epc_o.
- R9: With no valid pending stage, redirect_o and flush_o stay 0, epc_o, cause_o and cerr_o hold their values, and every valid stage's write requests pass through.
- R10: While redirect_o is high, no exception is accepted and every rf_we_o and mem_we_o is 0.
- R11: After reset, redirect_o, flush_o, epc_o, cause_o and cerr_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stg_valid_i | input | NSTG | Per-stage valid bit |
| stg_pend_i | input | NSTG | Per-stage exception pending bit |
| stg_cause_i | input | NSTG x CW | Per-stage cause code |
| stg_pc_i | input | NSTG x PCW | Per-stage virtual PC |
| stg_ldhit_i | input | NSTG | Per-stage load hit in cache |
| stg_rf_we_i | input | NSTG | Per-stage register write request |
| stg_mem_we_i | input | NSTG | Per-stage memory write request |
| rf_we_o | output | NSTG | Gated register write enables |
| mem_we_o | output | NSTG | Gated memory write enables |
| redirect_o | output | 1 | One-cycle redirect strobe |
| vector_o | output | PCW | Handler vector address |
| flush_o | output | NSTG-1 | Flush of fetch through memory stages |
| epc_o | output | PCW | Exception-PC register |
| cause_o | output | CW | Cause register |
| cerr_o | output | PCW | Cache-error address register |

## Verification
The bench sweeps all 32 pending patterns with every stage valid and gives each stage a distinct PC and cause. This shows whether the oldest stage is chosen rather than the youngest or some fixed stage, and whether the write gating splits at exactly the right stage. A sweep over the valid patterns, with every stage pending, shows whether invalid stages are really ignored. Each acceptance is followed by a strobe cycle in which all stages fault, which separates a correct post-acceptance blind window from a repeated redirect. Parity-error loads in the writeback and memory stages, one with its load-hit flag and one without, show the write exemption and the cache-error load apart from ordinary faults.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned CAUSE_W      = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_PARITY = 5'd16;
endpackage

// File: rtl/exc_oldest_sel.sv
// Picks the highest-indexed (oldest) stage with a pending valid exception.
module exc_oldest_sel #(
  parameter int unsigned NSTG = 5,
  localparam int unsigned SW  = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic [NSTG-1:0] pend_i,
  output logic            hit_o,
  output logic [SW-1:0]   sel_o
);
  always_comb begin
    hit_o = 1'b0;
    sel_o = '0;
    for (int i = 0; i < NSTG; i++) begin
      if (pend_i[i]) begin
        hit_o = 1'b1;
        sel_o = SW'(i);
      end
    end
  end
endmodule

// File: rtl/exc_kill_mask.sv
// Marks the accepted stage and all younger stages as killed.
module exc_kill_mask #(
  parameter int unsigned NSTG = 5,
  localparam int unsigned SW  = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic            hit_i,
  input  logic [SW-1:0]   sel_i,
  input  logic            blind_i,
  output logic [NSTG-1:0] kill_o,
  output logic [NSTG-1:0] fault_o
);
  for (genvar g = 0; g < NSTG; g++) begin : g_mask
    assign fault_o[g] = hit_i && !blind_i && (sel_i == SW'(g));
    assign kill_o[g]  = blind_i || (hit_i && (SW'(g) <= sel_i));
  end
endmodule

// File: rtl/exc_state_regs.sv
// Redirect strobe, flush and the exception state registers.
module exc_state_regs #(
  parameter int unsigned NSTG = 5,
  parameter int unsigned PCW  = 32,
  parameter int unsigned CW   = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take_i,
  input  logic            cerr_we_i,
  input  logic [PCW-1:0]  pc_i,
  input  logic [CW-1:0]   cause_i,
  output logic            redirect_o,
  output logic [NSTG-2:0] flush_o,
  output logic [PCW-1:0]  epc_o,
  output logic [CW-1:0]   cause_o,
  output logic [PCW-1:0]  cerr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_o <= 1'b0;
      flush_o    <= '0;
      epc_o      <= '0;
      cause_o    <= '0;
      cerr_o     <= '0;
    end else begin
      redirect_o <= take_i;
      flush_o    <= {(NSTG-1){take_i}};
      if (take_i) begin
        epc_o   <= pc_i;
        cause_o <= cause_i;
      end
      if (take_i && cerr_we_i) cerr_o <= pc_i;
    end
  end
endmodule

// File: rtl/exc_commit_unit.sv
module exc_commit_unit #(
  parameter int unsigned NSTG = 5,
  parameter int unsigned PCW  = 32,
  parameter int unsigned CW   = exc_pkg::CAUSE_W,
  parameter logic [PCW-1:0] HANDLER_VEC = 32'h0000_0180,
  parameter logic [CW-1:0]  PARITY_CODE = exc_pkg::CAUSE_PARITY,
  localparam int unsigned SW = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NSTG-1:0]          stg_valid_i,
  input  logic [NSTG-1:0]          stg_pend_i,
  input  logic [NSTG-1:0][CW-1:0]  stg_cause_i,
  input  logic [NSTG-1:0][PCW-1:0] stg_pc_i,
  input  logic [NSTG-1:0]          stg_ldhit_i,
  input  logic [NSTG-1:0]          stg_rf_we_i,
  input  logic [NSTG-1:0]          stg_mem_we_i,
  output logic [NSTG-1:0]          rf_we_o,
  output logic [NSTG-1:0]          mem_we_o,
  output logic                     redirect_o,
  output logic [PCW-1:0]           vector_o,
  output logic [NSTG-2:0]          flush_o,
  output logic [PCW-1:0]           epc_o,
  output logic [CW-1:0]            cause_o,
  output logic [PCW-1:0]           cerr_o
);
  logic [NSTG-1:0] pend_v, kill, fault;
  logic            hit, take, par_sel;
  logic [SW-1:0]   sel;

  assign pend_v = stg_valid_i & stg_pend_i;

  exc_oldest_sel #(.NSTG(NSTG)) u_sel (
    .pend_i (pend_v),
    .hit_o  (hit),
    .sel_o  (sel)
  );

  exc_kill_mask #(.NSTG(NSTG)) u_kill (
    .hit_i   (hit),
    .sel_i   (sel),
    .blind_i (redirect_o),
    .kill_o  (kill),
    .fault_o (fault)
  );

  assign take    = hit && !redirect_o;
  assign par_sel = (stg_cause_i[sel] == PARITY_CODE) && stg_ldhit_i[sel];

  for (genvar g = 0; g < NSTG; g++) begin : g_gate
    logic exempt;
    assign exempt      = fault[g] && par_sel;
    assign rf_we_o[g]  = stg_valid_i[g] && stg_rf_we_i[g] && (!kill[g] || exempt);
    assign mem_we_o[g] = stg_valid_i[g] && stg_mem_we_i[g] && !kill[g];
  end

  assign vector_o = HANDLER_VEC;

  exc_state_regs #(.NSTG(NSTG), .PCW(PCW), .CW(CW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .take_i     (take),
    .cerr_we_i  (par_sel),
    .pc_i       (stg_pc_i[sel]),
    .cause_i    (stg_cause_i[sel]),
    .redirect_o (redirect_o),
    .flush_o    (flush_o),
    .epc_o      (epc_o),
    .cause_o    (cause_o),
    .cerr_o     (cerr_o)
  );
endmodule

// File: rtl/exc_commit_chk.sv
module exc_commit_chk #(
  parameter int unsigned NSTG = 5
) (
  input logic            clk,
  input logic            rst,
  input logic [NSTG-1:0] stg_valid_i,
  input logic [NSTG-1:0] stg_pend_i,
  input logic [NSTG-1:0] stg_rf_we_i,
  input logic [NSTG-1:0] stg_mem_we_i,
  input logic [NSTG-1:0] rf_we_o,
  input logic [NSTG-1:0] mem_we_o,
  input logic            redirect_o,
  input logic [NSTG-2:0] flush_o
);
  logic [NSTG-1:0] pend_up;
  always_comb begin
    pend_up[NSTG-1] = stg_valid_i[NSTG-1] && stg_pend_i[NSTG-1];
    for (int i = NSTG-2; i >= 0; i--)
      pend_up[i] = pend_up[i+1] || (stg_valid_i[i] && stg_pend_i[i]);
  end

  // R7
  redirect_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_o |=> !redirect_o);
  // R9
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pend_up[0] |=> !redirect_o);
  // R10
  blind_window_chk: assert property (@(posedge clk) disable iff (rst)
    redirect_o |-> (rf_we_o == '0 && mem_we_o == '0));
  // R7
  flush_match_chk: assert property (@(posedge clk) disable iff (rst)
    (flush_o == '0) || (redirect_o && flush_o == '1));

  for (genvar g = 0; g < NSTG; g++) begin : g_we
    // R3
    mem_gate_chk: assert property (@(posedge clk) disable iff (rst)
      mem_we_o[g] |-> (stg_mem_we_i[g] && !pend_up[g]));
    // R2
    rf_req_chk: assert property (@(posedge clk) disable iff (rst)
      rf_we_o[g] |-> (stg_rf_we_i[g] && stg_valid_i[g]));
  end
endmodule

bind exc_commit_unit exc_commit_chk #(.NSTG(NSTG)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .stg_valid_i  (stg_valid_i),
  .stg_pend_i   (stg_pend_i),
  .stg_rf_we_i  (stg_rf_we_i),
  .stg_mem_we_i (stg_mem_we_i),
  .rf_we_o      (rf_we_o),
  .mem_we_o     (mem_we_o),
  .redirect_o   (redirect_o),
  .flush_o      (flush_o)
);

// File: tb/exc_commit_unit_tb.sv
module exc_commit_unit_tb;
  localparam int NSTG = 5;
  localparam int PCW  = 32;
  localparam int CW   = 5;
  localparam logic [PCW-1:0] VEC = 32'h0000_0180;

  logic clk = 1'b0, rst = 1'b1;
  logic [NSTG-1:0] valid, pend, ldhit, rfwe, memwe;
  logic [NSTG-1:0][CW-1:0]  cause;
  logic [NSTG-1:0][PCW-1:0] pc;
  logic [NSTG-1:0] rf_we_o, mem_we_o;
  logic redirect_o;
  logic [PCW-1:0] vector_o, epc_o, cerr_o;
  logic [NSTG-2:0] flush_o;
  logic [CW-1:0] cause_o;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [PCW-1:0] exp_epc = '0, exp_cerr = '0;
  logic [CW-1:0]  exp_cause = '0;

  always #4 clk = ~clk;

  exc_commit_unit u_dut (
    .clk(clk), .rst(rst), .stg_valid_i(valid), .stg_pend_i(pend),
    .stg_cause_i(cause), .stg_pc_i(pc), .stg_ldhit_i(ldhit),
    .stg_rf_we_i(rfwe), .stg_mem_we_i(memwe), .rf_we_o(rf_we_o),
    .mem_we_o(mem_we_o), .redirect_o(redirect_o), .vector_o(vector_o),
    .flush_o(flush_o), .epc_o(epc_o), .cause_o(cause_o), .cerr_o(cerr_o));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic idle();
    valid = '0; pend = '0; ldhit = '0; rfwe = '0; memwe = '0;
    for (int i = 0; i < NSTG; i++) begin
      cause[i] = CW'(i + 1);
      pc[i] = 32'h1000 + 32'(i * 4);
    end
  endtask

  function automatic int oldest(input logic [NSTG-1:0] m);
    int r = -1;
    for (int i = 0; i < NSTG; i++) if (m[i]) r = i;
    return r;
  endfunction

  // Applies current inputs for one acceptance cycle and checks the results.
  task automatic run_case(input string tag);
    logic [NSTG-1:0] er, em, m;
    int s;
    bit par;
    m = valid & pend;
    s = oldest(m);
    par = (s >= 0) && (cause[s] == 5'd16) && ldhit[s];
    for (int i = 0; i < NSTG; i++) begin
      er[i] = valid[i] && rfwe[i] && ((i > s) || (i == s && par));
      em[i] = valid[i] && memwe[i] && (i > s);
    end
    #1;
    chk(rf_we_o == er, {tag, " R3 R5 R6 rf_we"}, rf_we_o, er);
    chk(mem_we_o == em, {tag, " R3 mem_we"}, mem_we_o, em);
    if (s >= 0) begin
      exp_epc = pc[s]; exp_cause = cause[s];
      if (par) exp_cerr = pc[s];
    end
    step();
    chk(redirect_o == (s >= 0), {tag, " R7 R9 redirect"}, redirect_o, s >= 0);
    chk(flush_o == ((s >= 0) ? 4'hF : 4'h0), {tag, " R7 flush"}, flush_o, (s >= 0) ? 4'hF : 4'h0);
    chk(epc_o == exp_epc, {tag, " R1 R4 epc"}, epc_o, exp_epc);
    chk(cause_o == exp_cause, {tag, " R8 cause"}, cause_o, exp_cause);
    chk(cerr_o == exp_cerr, {tag, " R5 R6 cerr"}, cerr_o, exp_cerr);
    if (s >= 0) begin
      valid = '1; pend = '1; rfwe = '1; memwe = '1;
      #1;
      chk(rf_we_o == '0 && mem_we_o == '0, {tag, " R10 blind gate"}, {rf_we_o, mem_we_o}, 0);
      step();
      chk(redirect_o == 1'b0, {tag, " R10 R7 no repeat"}, redirect_o, 0);
      chk(epc_o == exp_epc, {tag, " R10 epc hold"}, epc_o, exp_epc);
    end
    idle();
    step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    step(); step();
    rst = 1'b0;
    #1;
    // R11
    chk(redirect_o == 0 && flush_o == 0 && epc_o == 0 && cause_o == 0 && cerr_o == 0,
        "R11 reset", {redirect_o, flush_o, epc_o}, 0);
    chk(vector_o == VEC, "R7 vector", vector_o, VEC);
    step();
    // Exhaustive pending sweep, all valid, all writes requested
    for (int p = 0; p < 32; p++) begin
      valid = '1; pend = NSTG'(p); rfwe = '1; memwe = '1;
      for (int i = 0; i < NSTG; i++) pc[i] = 32'h4000 + 32'(p << 8) + 32'(i * 4);
      run_case($sformatf("pend=%0d R1", p));
    end
    // Valid sweep with all pending: R2
    for (int v = 0; v < 32; v++) begin
      valid = NSTG'(v); pend = '1; rfwe = '1; memwe = '1;
      for (int i = 0; i < NSTG; i++) pc[i] = 32'h8000 + 32'(v << 8) + 32'(i * 4);
      run_case($sformatf("valid=%0d R2", v));
    end
    // Parity load hit in writeback with younger faults
    valid = '1; pend = 5'b10101; rfwe = '1; memwe = '1; ldhit = 5'b10000;
    cause[4] = 5'd16; pc[4] = 32'hA0A0;
    run_case("R5 parity wb");
    // Parity code but no load hit: ordinary fault
    valid = '1; pend = 5'b10000; rfwe = '1; memwe = '1; ldhit = '0;
    cause[4] = 5'd16; pc[4] = 32'hB0B0;
    run_case("R6 parity no hit");
    // Parity load hit in memory stage, older wb still writes
    valid = '1; pend = 5'b01010; rfwe = '1; memwe = '1; ldhit = 5'b01000;
    cause[3] = 5'd16; pc[3] = 32'hC0C0;
    run_case("R5 parity mem");
    // Younger parity discarded under older ordinary fault
    valid = '1; pend = 5'b11000; rfwe = '1; memwe = '1; ldhit = 5'b01000;
    cause[3] = 5'd16; pc[3] = 32'hD0D0; cause[4] = 5'd3; pc[4] = 32'hE0E0;
    run_case("R4 younger parity");
    // Idle with no exceptions: registers hold
    valid = 5'b11011; rfwe = 5'b10101; memwe = 5'b01010;
    run_case("R9 idle");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule